// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the memory operand address for a small CPU core from an address register value, an addressing mode and an operand size. It handles two register-indirect forms that update the register: post-increment and pre-decrement. It also handles three absolute forms, whose address fields are 8, 16 or 24 bits wide. A mode select picks between a 24-bit (advanced) address space and a 16-bit (normal) address space.

The effective address and the alignment-error flag are combinational, so decode can present a request and use the address in the same cycle. The updated register value is registered and leaves the block one cycle after the request, together with a one-cycle write-back strobe that the register file uses to store it. The register file, instruction decode and memory bus are not part of this block.

Top module: `opaddr_gen`

## Requirements
- R1: With `mode_sel`=0 (post-increment), `ea` equals the lower 24 bits of `reg_val` as it was before the update.
- R2: For a valid post-increment access with no alignment error, `wb_en` is 1 in the cycle after the request, and `wb_data` equals `reg_val` plus the size step. The sum is computed on all 32 bits, so a carry out of bit 23 reaches the upper byte.
- R3: With `mode_sel`=1 (pre-decrement), the result is `reg_val` minus the size step, computed on 32 bits. `ea` is the lower 24 bits of that result. For a valid access with no error, the result appears on `wb_data` with `wb_en` in the next cycle.
- R4: `size_sel` encodes 0 as byte (step 1), 1 as word (step 2) and 2 as longword (step 4). Code 3 behaves as byte.
- R5: With `mode_sel`=2 (8-bit absolute), `ea` is `abs_field[7:0]` with every higher bit set to 1. This gives 0xFFFF00 to 0xFFFFFF.
- R6: With `mode_sel`=3 (16-bit absolute), `ea` is `abs_field[15:0]` with bits 23:16 copied from bit 15. `abs_field[23:16]` has no effect.
- R7: With `mode_sel`=4 (24-bit absolute), `ea` equals `abs_field` unchanged.
- R8: When `adv_mode`=0, `ea[23:16]` is 0 and the lower 16 bits follow R1–R7. An 8-bit absolute address then maps to 0xFF00 to 0xFFFF.
- R9: `addr_err` is 1 exactly when `in_valid` is 1, the size is word or longword, and `ea[0]` is 1. For an indirect mode this is the register value used (post-increment) or produced (pre-decrement). A byte access never raises it. A request with `addr_err` set produces no write-back.
- R10: Absolute modes, reserved mode codes (5 to 7) and cycles with `in_valid`=0 never assert `wb_en`. Each valid, error-free indirect request asserts `wb_en` for exactly one cycle.
- R11: While `rst` is 1, and in the first cycle after it, `wb_en` and `wb_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| mode_sel | input | 3 | Addressing mode: 0 post-inc, 1 pre-dec, 2 abs8, 3 abs16, 4 abs24 |
| size_sel | input | 2 | Operand size: 0 byte, 1 word, 2 longword |
| reg_val | input | 32 | Current address register contents |
| abs_field | input | 24 | Absolute address field from the instruction |
| adv_mode | input | 1 | 1 selects the 24-bit space, 0 the 16-bit space |
| ea | output | 24 | Effective address (combinational) |
| addr_err | output | 1 | Misaligned word or longword access (combinational) |
| wb_en | output | 1 | Register write-back strobe (registered) |
| wb_data | output | 32 | Updated register value (registered) |

## Verification
The bound checker checks these properties on every clock edge:
- the upper byte stays zero in normal mode;
- the 8-bit absolute form keeps all ones in its upper bits;
- a byte access never raises an alignment error;
- an error, an absolute mode or an idle cycle is never followed by a strobe;
- every strobe traces back to a valid, aligned, indirect request;
- the post-increment result differs from the old register by the size step;
- the pre-decrement write-back matches the address issued in the previous cycle.

Only the bench scenarios show the remaining cases. These are the exact sign-extension boundary at 0x7FFF/0x8000, that `abs_field[23:16]` is ignored in the 16-bit form, a carry or borrow that crosses bit 23 into the upper byte, and back-to-back requests each producing their own strobe in order.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  typedef enum logic [2:0] {
    AM_POSTINC = 3'd0,
    AM_PREDEC  = 3'd1,
    AM_ABS8    = 3'd2,
    AM_ABS16   = 3'd3,
    AM_ABS24   = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } osize_e;

endpackage

// File: rtl/opaddr_step.sv
// Size-dependent register step: 1, 2 or 4.
module opaddr_step #(
  parameter int REG_W = 32
) (
  input  logic [1:0]       size_sel,
  output logic [REG_W-1:0] step,
  output logic             wide
);
  import opaddr_pkg::*;

  always_comb begin
    step = REG_W'(1);
    wide = 1'b0;
    case (size_sel)
      SZ_WORD: begin step = REG_W'(2); wide = 1'b1; end
      SZ_LONG: begin step = REG_W'(4); wide = 1'b1; end
      default: begin step = REG_W'(1); wide = 1'b0; end
    endcase
  end
endmodule

// File: rtl/opaddr_abs_ext.sv
// Extends a short absolute field to the full address width.
module opaddr_abs_ext #(
  parameter int ADDR_W  = 24,
  parameter int SHORT_W = 8,
  parameter int MID_W   = 16
) (
  input  logic [2:0]        mode_sel,
  input  logic [ADDR_W-1:0] abs_field,
  output logic [ADDR_W-1:0] abs_addr
);
  import opaddr_pkg::*;

  localparam int SHORT_PAD = ADDR_W - SHORT_W;
  localparam int MID_PAD   = ADDR_W - MID_W;

  logic [ADDR_W-1:0] short_ext, mid_ext;

  assign short_ext = {{SHORT_PAD{1'b1}}, abs_field[SHORT_W-1:0]};
  assign mid_ext   = {{MID_PAD{abs_field[MID_W-1]}}, abs_field[MID_W-1:0]};

  always_comb begin
    case (mode_sel)
      AM_ABS8:  abs_addr = short_ext;
      AM_ABS16: abs_addr = mid_ext;
      AM_ABS24: abs_addr = abs_field;
      default:  abs_addr = '0;
    endcase
  end
endmodule

// File: rtl/opaddr_wb_reg.sv
// Output register for the write-back strobe and value.
module opaddr_wb_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d_en,
  input  logic [REG_W-1:0] d_data,
  output logic             q_en,
  output logic [REG_W-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_en   <= 1'b0;
      q_data <= '0;
    end else begin
      q_en   <= d_en;
      q_data <= d_en ? d_data : q_data;
    end
  end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 24,
  parameter int NORM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        mode_sel,
  input  logic [1:0]        size_sel,
  input  logic [REG_W-1:0]  reg_val,
  input  logic [ADDR_W-1:0] abs_field,
  input  logic              adv_mode,
  output logic [ADDR_W-1:0] ea,
  output logic              addr_err,
  output logic              wb_en,
  output logic [REG_W-1:0]  wb_data
);
  import opaddr_pkg::*;

  localparam int HI_W = ADDR_W - NORM_W;

  logic [REG_W-1:0]  step, inc_val, dec_val, next_val;
  logic              wide, indirect, wb_d_en;
  logic [ADDR_W-1:0] abs_addr, raw_addr;

  opaddr_step #(.REG_W(REG_W)) step_i (
    .size_sel (size_sel),
    .step     (step),
    .wide     (wide)
  );

  opaddr_abs_ext #(.ADDR_W(ADDR_W), .SHORT_W(8), .MID_W(16)) ext_i (
    .mode_sel  (mode_sel),
    .abs_field (abs_field),
    .abs_addr  (abs_addr)
  );

  assign inc_val = reg_val + step;
  assign dec_val = reg_val - step;

  always_comb begin
    indirect = 1'b0;
    next_val = inc_val;
    raw_addr = abs_addr;
    case (mode_sel)
      AM_POSTINC: begin
        indirect = 1'b1;
        next_val = inc_val;
        raw_addr = reg_val[ADDR_W-1:0];
      end
      AM_PREDEC: begin
        indirect = 1'b1;
        next_val = dec_val;
        raw_addr = dec_val[ADDR_W-1:0];
      end
      default: ;
    endcase
  end

  generate
    if (HI_W > 0) begin : g_space
      assign ea = adv_mode ? raw_addr : {{HI_W{1'b0}}, raw_addr[NORM_W-1:0]};
    end else begin : g_flat
      assign ea = raw_addr;
    end
  endgenerate

  assign addr_err = in_valid & wide & ea[0];
  assign wb_d_en  = in_valid & indirect & ~addr_err;

  opaddr_wb_reg #(.REG_W(REG_W)) wb_i (
    .clk    (clk),
    .rst    (rst),
    .d_en   (wb_d_en),
    .d_data (next_val),
    .q_en   (wb_en),
    .q_data (wb_data)
  );
endmodule

// File: rtl/opaddr_chk.sv
module opaddr_chk #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        mode_sel,
  input logic [1:0]        size_sel,
  input logic [REG_W-1:0]  reg_val,
  input logic              adv_mode,
  input logic [ADDR_W-1:0] ea,
  input logic              addr_err,
  input logic              wb_en,
  input logic [REG_W-1:0]  wb_data
);
  logic good_ind;
  assign good_ind = in_valid && (mode_sel == 3'd0 || mode_sel == 3'd1) && !addr_err;

  a_r8_normal_upper_zero: assert property (@(posedge clk) disable iff (rst)
    !adv_mode |-> ea[ADDR_W-1:16] == '0);

  a_r5_abs8_ones: assert property (@(posedge clk) disable iff (rst)
    (adv_mode && mode_sel == 3'd2) |-> ea[ADDR_W-1:8] == '1);

  a_r9_byte_never_err: assert property (@(posedge clk) disable iff (rst)
    (size_sel == 2'd0 || size_sel == 2'd3) |-> !addr_err);

  a_r9_err_no_wb: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> !wb_en);

  a_r10_abs_no_wb: assert property (@(posedge clk) disable iff (rst)
    (mode_sel > 3'd1 || !in_valid) |=> !wb_en);

  a_r10_wb_origin: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> $past(good_ind));

  a_r2_postinc_step: assert property (@(posedge clk) disable iff (rst)
    (good_ind && mode_sel == 3'd0) |=>
      (wb_en && wb_data - $past(reg_val) ==
        ($past(size_sel) == 2'd2 ? 32'd4 : $past(size_sel) == 2'd1 ? 32'd2 : 32'd1)));

  a_r3_predec_ea_match: assert property (@(posedge clk) disable iff (rst)
    (good_ind && mode_sel == 3'd1 && adv_mode) |=>
      (wb_en && wb_data[ADDR_W-1:0] == $past(ea)));
endmodule

bind opaddr_gen opaddr_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode_sel(mode_sel),
  .size_sel(size_sel), .reg_val(reg_val), .adv_mode(adv_mode), .ea(ea),
  .addr_err(addr_err), .wb_en(wb_en), .wb_data(wb_data)
);

// File: tb/opaddr_gen_tb.sv
module opaddr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  mode_sel = '0;
  logic [1:0]  size_sel = '0;
  logic [31:0] reg_val = '0;
  logic [23:0] abs_field = '0;
  logic        adv_mode = 1'b1;
  logic [23:0] ea;
  logic        addr_err, wb_en;
  logic [31:0] wb_data;

  int checks = 0;
  int failures = 0;

  typedef struct { logic wb; logic [31:0] data; string tag; } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  opaddr_gen dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_sel(mode_sel),
    .size_sel(size_sel), .reg_val(reg_val), .abs_field(abs_field),
    .adv_mode(adv_mode), .ea(ea), .addr_err(addr_err), .wb_en(wb_en),
    .wb_data(wb_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Reference model written from the requirements.
  task automatic model(input logic v, input logic [2:0] m, input logic [1:0] s,
                       input logic [31:0] r, input logic [23:0] f, input logic adv,
                       output logic [23:0] e, output logic err, output logic wb,
                       output logic [31:0] nv);
    logic [31:0] st;
    logic [23:0] full;
    st = (s == 2'd2) ? 32'd4 : (s == 2'd1) ? 32'd2 : 32'd1;
    nv = 32'd0;
    wb = 1'b0;
    case (m)
      3'd0: begin full = r[23:0]; nv = r + st; wb = 1'b1; end
      3'd1: begin nv = r - st; full = nv[23:0]; wb = 1'b1; end
      3'd2: full = {16'hFFFF, f[7:0]};
      3'd3: full = {{8{f[15]}}, f[15:0]};
      3'd4: full = f;
      default: full = 24'd0;
    endcase
    e = adv ? full : {8'h00, full[15:0]};
    err = v && (s == 2'd1 || s == 2'd2) && e[0];
    wb = wb && v && !err;
  endtask

  task automatic drive(input logic v, input logic [2:0] m, input logic [1:0] s,
                       input logic [31:0] r, input logic [23:0] f, input logic adv,
                       input string tag);
    logic [23:0] e; logic err, wb; logic [31:0] nv;
    exp_t it;
    @(negedge clk);
    in_valid = v; mode_sel = m; size_sel = s; reg_val = r; abs_field = f; adv_mode = adv;
    model(v, m, s, r, f, adv, e, err, wb, nv);
    #1;
    check(ea == e, {tag, " ea"}, {8'h0, ea}, {8'h0, e});
    check(addr_err == err, {tag, " addr_err"}, {31'h0, addr_err}, {31'h0, err});
    it.wb = wb; it.data = nv; it.tag = tag;
    expq.push_back(it);
  endtask

  // Monitor: compares the registered write-back after each edge.
  always @(posedge clk) begin
    #2;
    if (!rst && expq.size() > 0) begin
      exp_t it;
      it = expq.pop_front();
      check(wb_en == it.wb, {it.tag, " wb_en"}, {31'h0, wb_en}, {31'h0, it.wb});
      if (it.wb)
        check(wb_data == it.data, {it.tag, " wb_data"}, wb_data, it.data);
    end else if (!rst && wb_en) begin
      check(1'b0, "R10 spurious wb_en", {31'h0, wb_en}, 32'h0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(wb_en == 1'b0, "R11 reset wb_en", {31'h0, wb_en}, 32'h0);
    check(wb_data == 32'h0, "R11 reset wb_data", wb_data, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(wb_en == 1'b0 && wb_data == 32'h0, "R11 after reset", wb_data, 32'h0);

    drive(1, 3'd0, 2'd2, 32'h12345678, 24'h0, 1, "R1 R2 R4 postinc long");
    drive(1, 3'd0, 2'd0, 32'h00000001, 24'h0, 1, "R9 R4 postinc byte odd");
    drive(1, 3'd0, 2'd1, 32'h00FFFFFE, 24'h0, 1, "R2 postinc word carry");
    drive(1, 3'd0, 2'd3, 32'h00000010, 24'h0, 1, "R4 reserved size as byte");
    drive(1, 3'd1, 2'd1, 32'h00001000, 24'h0, 1, "R3 predec word");
    drive(1, 3'd1, 2'd2, 32'h00000002, 24'h0, 1, "R3 predec long borrow");
    drive(1, 3'd1, 2'd0, 32'h00000010, 24'h0, 1, "R3 predec byte");
    drive(1, 3'd0, 2'd1, 32'h00000101, 24'h0, 1, "R9 postinc word odd");
    drive(1, 3'd1, 2'd2, 32'h00000005, 24'h0, 1, "R9 predec long odd result");
    drive(1, 3'd1, 2'd1, 32'h00000004, 24'h0, 1, "R9 predec word even result");
    drive(1, 3'd2, 2'd0, 24'h123442, 24'h123442, 1, "R5 abs8 adv");
    drive(1, 3'd2, 2'd0, 32'h0, 24'h000042, 0, "R8 abs8 normal");
    drive(1, 3'd3, 2'd0, 32'h0, 24'h008000, 1, "R6 abs16 negative");
    drive(1, 3'd3, 2'd0, 32'h0, 24'h007FFF, 1, "R6 abs16 positive");
    drive(1, 3'd3, 2'd0, 32'h0, 24'hAB1234, 1, "R6 abs16 upper field ignored");
    drive(1, 3'd3, 2'd0, 32'h0, 24'h008000, 0, "R8 abs16 normal");
    drive(1, 3'd4, 2'd2, 32'h0, 24'hABCDEF, 1, "R7 abs24 odd long");
    drive(1, 3'd4, 2'd1, 32'h0, 24'hABCDEE, 1, "R7 R10 abs24 word");
    drive(1, 3'd3, 2'd1, 32'h0, 24'h000011, 1, "R9 abs16 word odd");
    drive(1, 3'd0, 2'd2, 32'h00123456, 24'h0, 0, "R8 postinc normal");
    drive(1, 3'd6, 2'd0, 32'h00000100, 24'h0, 1, "R10 reserved mode");
    drive(0, 3'd0, 2'd1, 32'h00000201, 24'h0, 1, "R10 R9 idle postinc");
    drive(0, 3'd1, 2'd0, 32'h00000300, 24'h0, 1, "R10 idle predec");
    drive(1, 3'd0, 2'd0, 32'hFFFFFFFF, 24'h0, 1, "R2 postinc wrap");
    drive(1, 3'd1, 2'd2, 32'h80000000, 24'h0, 1, "R3 predec top");
    drive(1, 3'd0, 2'd1, 32'h00000200, 24'h0, 1, "R10 back to back a");
    drive(1, 3'd0, 2'd1, 32'h00000202, 24'h0, 1, "R10 back to back b");
    drive(0, 3'd0, 2'd0, 32'h0, 24'h0, 1, "R10 drain");
    drive(0, 3'd0, 2'd0, 32'h0, 24'h0, 1, "R10 drain");

    while (expq.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule